// File: doc/BRIEF.md
# Sequential Non-Restoring Divider

This block divides an N-bit unsigned dividend by an N/2-bit unsigned divisor. The quotient and the remainder are each N/2 bits wide. A control state machine runs a small datapath. The datapath holds a partial-remainder register, a quotient shift register, the captured divisor and one adder/subtractor. In each step the datapath shifts the partial remainder left, pulling in the top bit of the quotient register. It then adds or subtracts the divisor. The complement of the sign of the result goes into the quotient register as the new bit. If the partial remainder is negative at the end, one correction step adds the divisor back.

A user drives the operands and raises `start` while the block is idle. The operands are captured one cycle later. The results appear on registered outputs together with a one-cycle `done` strobe, and they hold until the next strobe. The add/subtract choice is a clocked register. It keeps its value through every state that does not write it. Operands are valid when the divisor is nonzero and the upper half of the dividend is below the divisor, which means the quotient fits in N/2 bits. Other operands give undefined results.

Top module: `divnr_top`

## Requirements
- R1: While reset is high and after it is released, `done` is 0 and `quotient` and `remainder` are all zeros.
- R2: While the block is idle and `start` is 0, it stays idle: no `done` pulse appears, and the outputs keep their values.
- R3: If `start` is 1 at a clock edge while the block is idle, `done` goes high exactly N+2 clock edges later (N/2 = H; latency 2H+2). It stays high for exactly one cycle.
- R4: For valid operands, `quotient` equals floor(dividend / divisor) in the cycle where `done` is 1.
- R5: For valid operands, `remainder` equals dividend mod divisor in the cycle where `done` is 1. It is therefore strictly smaller than the divisor.
- R6: Operands are captured only when an operation begins. Changing `dividend`, `divisor` or `start` during an operation does not change its result and does not start a second operation.
- R7: `quotient` and `remainder` keep their values between `done` pulses, whatever the inputs do.
- R8: The add/subtract select is a register. The first step of each operation always subtracts. After each step, the select is set to subtract if the sign of the result is 0 and to add if it is 1. All other states leave it unchanged.
- R9: If `start` is held at 1 continuously, the operations run back to back, and `done` pulses once every 2H+3 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation; sampled only while idle |
| dividend | input | N | Unsigned dividend |
| divisor | input | N/2 | Unsigned divisor, nonzero |
| quotient | output | N/2 | Registered quotient |
| remainder | output | N/2 | Registered remainder |
| done | output | 1 | One-cycle strobe marking valid results |

## Verification
The bench builds the block with the default N = 16, so each operation takes eight shift steps and finishes 18 edges after `start`. At this size the extreme operands can all be exercised: divisor 1, divisor 255, the largest valid dividend, and quotients of 0 and 255. Many random operand pairs also run, and they reach both the case where the final correction is needed and the case where it is not. The same width is used to measure the fixed latency and the back-to-back period exactly.

// File: rtl/divnr_pkg.sv
package divnr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_INIT,
    ST_SUB,
    ST_TEST,
    ST_OPER,
    ST_FIN
  } divnr_state_e;
endpackage

// File: rtl/divnr_ctrl.sv
module divnr_ctrl
  import divnr_pkg::*;
#(
  parameter int H = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic sign,
  output logic init_en,
  output logic a_en,
  output logic q_en,
  output logic fin_en,
  output logic op_sub
);
  localparam int CW = (H > 1) ? $clog2(H) : 1;
  localparam logic [CW-1:0] LAST = CW'(H - 1);

  divnr_state_e state_q, state_d;
  logic [CW-1:0] cnt_q;
  logic          sel_q;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (start) state_d = ST_INIT;
      ST_INIT: state_d = ST_SUB;
      ST_SUB:  state_d = ST_TEST;
      ST_TEST: state_d = (cnt_q == LAST) ? ST_FIN : ST_OPER;
      ST_OPER: state_d = ST_TEST;
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sel_q   <= 1'b1;
    end else begin
      state_q <= state_d;
      case (state_q)
        ST_INIT: cnt_q <= '0;
        ST_SUB:  sel_q <= 1'b1;
        ST_TEST: begin
          sel_q <= ~sign;
          if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign init_en = (state_q == ST_INIT);
  assign a_en    = (state_q == ST_SUB) || (state_q == ST_OPER);
  assign q_en    = (state_q == ST_TEST);
  assign fin_en  = (state_q == ST_FIN);
  assign op_sub  = (state_q == ST_SUB) ? 1'b1 : sel_q;

  AST_SEL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (state_q != ST_SUB && state_q != ST_TEST) |=> $stable(sel_q)); // R8
  AST_SEL_FIRST_SUB: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_SUB) |=> sel_q); // R8
  AST_SEL_FROM_SIGN: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_TEST) |=> (sel_q == !$past(sign))); // R8
  AST_IDLE_WAIT: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && !start) |=> (state_q == ST_IDLE)); // R2
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST); // R3
endmodule

// File: rtl/divnr_dp.sv
module divnr_dp #(
  parameter int N = 16,
  parameter int H = N / 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         init_en,
  input  logic         a_en,
  input  logic         q_en,
  input  logic         fin_en,
  input  logic         op_sub,
  input  logic [N-1:0] dividend,
  input  logic [H-1:0] divisor,
  output logic         sign,
  output logic [H-1:0] quotient,
  output logic [H-1:0] remainder,
  output logic         done
);
  logic [H:0]   a_q;
  logic [H-1:0] q_q;
  logic [H-1:0] d_q;
  logic [H:0]   shifted;
  logic [H:0]   dext;
  logic [H:0]   alu;
  logic [H-1:0] corr;

  assign shifted = {a_q[H-1:0], q_q[H-1]};
  assign dext    = {1'b0, d_q};
  assign alu     = op_sub ? (shifted - dext) : (shifted + dext);
  assign corr    = a_q[H] ? (a_q[H-1:0] + d_q) : a_q[H-1:0];
  assign sign    = a_q[H];

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q       <= '0;
      q_q       <= '0;
      d_q       <= '0;
      quotient  <= '0;
      remainder <= '0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      if (init_en) begin
        a_q <= {1'b0, dividend[N-1:H]};
        q_q <= dividend[H-1:0];
        d_q <= divisor;
      end
      if (a_en) a_q <= alu;
      if (q_en) q_q <= {q_q[H-2:0], ~a_q[H]};
      if (fin_en) begin
        quotient  <= q_q;
        remainder <= corr;
        done      <= 1'b1;
      end
    end
  end

  AST_REM_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (rst)
    done |-> (remainder < d_q)); // R5
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !fin_en |=> ($stable(quotient) && $stable(remainder))); // R7
endmodule

// File: rtl/divnr_top.sv
module divnr_top #(
  parameter int N = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [N-1:0]     dividend,
  input  logic [N/2-1:0]   divisor,
  output logic [N/2-1:0]   quotient,
  output logic [N/2-1:0]   remainder,
  output logic             done
);
  localparam int H = N / 2;

  logic init_en, a_en, q_en, fin_en, op_sub, sign;

  divnr_ctrl #(.H(H)) ctrl_i (
    .clk(clk), .rst(rst), .start(start), .sign(sign),
    .init_en(init_en), .a_en(a_en), .q_en(q_en),
    .fin_en(fin_en), .op_sub(op_sub)
  );

  divnr_dp #(.N(N), .H(H)) dp_i (
    .clk(clk), .rst(rst), .init_en(init_en), .a_en(a_en), .q_en(q_en),
    .fin_en(fin_en), .op_sub(op_sub), .dividend(dividend),
    .divisor(divisor), .sign(sign), .quotient(quotient),
    .remainder(remainder), .done(done)
  );

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R3
  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!done && quotient == '0 && remainder == '0)); // R1
endmodule

// File: tb/divnr_top_tb_top.sv
module divnr_top_tb_top;
  localparam int N = 16;
  localparam int H = N / 2;
  localparam int CLK_PERIOD = 10;
  localparam int LAT = 2 * H + 2;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [N-1:0] dividend = '0;
  logic [H-1:0] divisor = '0;
  logic [H-1:0] quotient, remainder;
  logic         done;

  int n_tests = 0;
  int n_fail  = 0;
  int seed    = 7;

  always #(CLK_PERIOD / 2) clk = ~clk;

  divnr_top #(.N(N)) dut_i (
    .clk(clk), .rst(rst), .start(start), .dividend(dividend),
    .divisor(divisor), .quotient(quotient), .remainder(remainder),
    .done(done)
  );

  task automatic check(input string req, input longint act, input longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One operation: start pulse, count edges to done, check results
  task automatic run_op(input logic [H-1:0] q, input logic [H-1:0] d, input logic [H-1:0] r);
    int n;
    logic [N-1:0] dv;
    dv = N'(q) * N'(d) + N'(r);
    @(negedge clk);
    dividend = dv; divisor = d; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (n < 4 * LAT) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (done) break;
    end
    check("R3 latency", n, LAT);
    check("R4 quotient", quotient, q);
    check("R5 remainder", remainder, r);
    @(posedge clk); @(negedge clk);
    check("R3 done width", done, 0);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R1 done", done, 0);
    check("R1 quotient", quotient, 0);
    check("R1 remainder", remainder, 0);
  endtask

  task automatic t_idle;
    int seen = 0;
    @(negedge clk);
    dividend = 16'h1234; divisor = 8'h55;
    for (int i = 0; i < 3 * LAT; i++) begin
      @(negedge clk);
      if (done) seen++;
    end
    check("R2 no done while idle", seen, 0);
    check("R2 quotient unchanged", quotient, 0);
  endtask

  task automatic t_directed;
    run_op(8'd0, 8'd1, 8'd0);
    run_op(8'd255, 8'd1, 8'd0);
    run_op(8'd255, 8'd255, 8'd254);
    run_op(8'd0, 8'd255, 8'd254);
    run_op(8'd1, 8'd128, 8'd127);
    run_op(8'd100, 8'd7, 8'd6);
    run_op(8'd170, 8'd3, 8'd0);
  endtask

  task automatic t_random;
    logic [H-1:0] q, d, r;
    for (int i = 0; i < 150; i++) begin
      q = H'($urandom(seed) % 256);
      seed++;
      d = H'(($urandom(seed) % 255) + 1);
      seed++;
      r = H'($urandom(seed) % d);
      seed++;
      run_op(q, d, r);
    end
  endtask

  task automatic t_busy;
    int n, extra;
    @(negedge clk);
    dividend = 16'd1000; divisor = 8'd9; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    n = 0;
    repeat (4) begin @(posedge clk); n++; @(negedge clk); end
    dividend = 16'd50; divisor = 8'd200; start = 1'b1;
    @(posedge clk); n++; @(negedge clk);
    start = 1'b0;
    while (n < 4 * LAT) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (done) break;
    end
    check("R6 latency unchanged", n, LAT);
    check("R6 quotient of first operands", quotient, 111);
    check("R6 remainder of first operands", remainder, 1);
    extra = 0;
    for (int i = 0; i < 2 * LAT; i++) begin
      @(negedge clk);
      if (done) extra++;
    end
    check("R6 no second operation", extra, 0);
  endtask

  task automatic t_hold;
    @(negedge clk);
    dividend = 16'hFFFF; divisor = 8'd1;
    repeat (10) @(negedge clk);
    check("R7 quotient held", quotient, 111);
    check("R7 remainder held", remainder, 1);
  endtask

  task automatic t_b2b;
    int t = 0, first = -1, second = -1;
    @(negedge clk);
    dividend = 16'd5000; divisor = 8'd77; start = 1'b1;
    while (t < 6 * LAT && second < 0) begin
      @(posedge clk); t++;
      @(negedge clk);
      if (done) begin
        if (first < 0) first = t; else second = t;
        check("R9 quotient", quotient, 64);
        check("R9 remainder", remainder, 72);
      end
    end
    start = 1'b0;
    check("R9 period", second - first, LAT + 1);
    repeat (3 * LAT) @(negedge clk);
  endtask

  initial begin
    t_reset();
    t_idle();
    t_directed();
    t_random();
    t_busy();
    t_hold();
    t_b2b();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule